// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects twelve level-sensitive interrupt request lines from peripherals and gives the CPU a single request together with a vector address. Software assigns every source a two-bit urgency level through three byte-wide level registers. Each source also has an enable bit. Of the sources that are both pending and enabled, the block picks the most urgent level, and it breaks ties by the lowest source index.

A small stack of service levels tracks nested routines. When the CPU acknowledges a request, the granted level is pushed onto the stack. A return pulse pops it. While a routine is in service, only a strictly more urgent source is offered. A source at the same level or a lower one waits until the return pulse. Any enabled pending source raises a wake output, whatever the service level, so that the CPU can leave standby.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset all level fields are 0, `int_req` is 0, `vec_addr` is 0, `grant_id` and `grant_lvl` are 0, and `in_service` is 0.
- R2: Register address 0 holds the fields for sources 0..3, address 1 holds sources 4..7 and address 2 holds sources 8..11. Source k uses bits [2*(k%4)+1 : 2*(k%4)] of its register. A write takes effect in the cycle after the write edge, and `reg_rdata` returns the fields combinationally for `reg_addr`.
- R3: Address 3 reads as 0 and ignores writes. A write there leaves all other registers unchanged.
- R4: A source is a candidate only when both `irq_req[k]` and `irq_en[k]` are 1. `wake` is 1 exactly when at least one source is a candidate.
- R5: Among the candidates, the highest level code wins. Code 3 is the most urgent and code 0 the least. `grant_lvl` shows the winning level.
- R6: Among candidates at the same level, the lowest index wins, and `grant_id` shows that index.
- R7: While `int_req` is 1, `vec_addr` is 16'hFFFA minus two times `grant_id` (FFFA for source 0, FFE4 for source 11). While `int_req` is 0, `vec_addr`, `grant_id` and `grant_lvl` are 0.
- R8: With the stack empty, any candidate raises `int_req`. With the stack non-empty, `int_req` is 1 only when the winner's level is strictly above `cur_lvl`. `ack` with `int_req` at 1 pushes `grant_lvl` at the clock edge, after which `in_service` is 1 and `cur_lvl` equals the pushed level.
- R9: `reti` pops the stack at the edge and restores the previous level. `reti` on an empty stack has no effect. When `ack` and `reti` arrive in the same cycle, only the pop happens.
- R10: The stack holds at most four levels, and a push is never made while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 12 | Pending request lines, one per source |
| irq_en | input | 12 | Per-source request enables |
| reg_wr | input | 1 | Level register write strobe |
| reg_addr | input | 2 | Level register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ack | input | 1 | CPU accepts the offered request |
| reti | input | 1 | Return from current routine |
| int_req | output | 1 | Request offered to the CPU |
| vec_addr | output | 16 | Vector upper-byte address of the offered source |
| grant_id | output | 4 | Index of the offered source |
| grant_lvl | output | 2 | Level of the offered source |
| cur_lvl | output | 2 | Level at top of the service stack (0 if empty) |
| in_service | output | 1 | Service stack non-empty |
| wake | output | 1 | Any enabled pending source |

## Verification
Changes on the request and enable lines reach `int_req`, `vec_addr`, `grant_id`, `grant_lvl` and `wake` in the same cycle with no register on the path, so the bench samples them one time step after driving. Register writes, `ack` and `reti` act at a clock edge, and their results are due in the cycle that follows. For these the bench holds the strobe across exactly one rising edge and samples two nanoseconds after that edge. Each expected item comes from a bench-side model of the level fields and the service stack. It is queued at the sampling instant and compared by a separate monitor.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NSRC  = 12,
  parameter int LVLW  = 2,
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int DW    = 8,
  parameter int VW    = 16,
  parameter logic [15:0] VBASE = 16'hFFFA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            ack,
  input  logic            reti,
  output logic            int_req,
  output logic [VW-1:0]   vec_addr,
  output logic [$clog2(NSRC)-1:0] grant_id,
  output logic [LVLW-1:0] grant_lvl,
  output logic [LVLW-1:0] cur_lvl,
  output logic            in_service,
  output logic            wake
);
  localparam int FPR = DW / LVLW;
  localparam int IDW = $clog2(NSRC);
  localparam int DPW = $clog2(DEPTH + 1);
  localparam int SPW = $clog2(DEPTH);

  logic [LVLW-1:0] lvl_q [NSRC];
  logic [LVLW-1:0] stk_q [DEPTH];
  logic [DPW-1:0]  depth_q;
  logic [NSRC-1:0] cand;
  logic            found;
  logic [LVLW-1:0] best;
  logic [IDW-1:0]  bid;
  logic [LVLW-1:0] top;
  logic            push, pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NSRC; i++)
        if (reg_addr == AW'(i / FPR))
          lvl_q[i] <= reg_wdata[(i % FPR)*LVLW +: LVLW];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      if (reg_addr == AW'(i / FPR))
        reg_rdata[(i % FPR)*LVLW +: LVLW] = lvl_q[i];
  end

  assign cand = irq_req & irq_en;
  assign wake = |cand;

  always_comb begin
    found = 1'b0;
    best  = '0;
    bid   = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (cand[i] && (!found || lvl_q[i] >= best)) begin
        found = 1'b1;
        best  = lvl_q[i];
        bid   = IDW'(i);
      end
  end

  assign top        = (depth_q == '0) ? '0 : stk_q[SPW'(depth_q - 1'b1)];
  assign in_service = (depth_q != '0);
  assign cur_lvl    = top;
  assign int_req    = found && (!in_service || best > top);
  assign grant_id   = int_req ? bid : '0;
  assign grant_lvl  = int_req ? best : '0;
  assign vec_addr   = int_req ? (VBASE - (VW'(bid) << 1)) : '0;

  assign pop  = reti && in_service;
  assign push = ack && int_req && !reti && (depth_q < DPW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (pop) begin
      depth_q <= depth_q - 1'b1;
    end else if (push) begin
      stk_q[SPW'(depth_q)] <= best;
      depth_q <= depth_q + 1'b1;
    end
  end

  p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> wake);

  p_offer_beats_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && in_service) |-> (grant_lvl > cur_lvl));

  p_push_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req && !reti) |=> (in_service && cur_lvl == $past(grant_lvl)));

  p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !in_service) |=> !in_service);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req) |-> (depth_q < DPW'(DEPTH)));

  p_idle_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_req |-> (vec_addr == '0 && grant_id == '0));
endmodule

// File: tb/tb_lvl_irq_ctrl.sv
module tb_lvl_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [11:0] irq_req = '0, irq_en = '0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic ack = 0, reti = 0;
  logic int_req, in_service, wake;
  logic [15:0] vec_addr;
  logic [3:0] grant_id;
  logic [1:0] grant_lvl, cur_lvl;

  lvl_irq_ctrl dut (.*);

  always #10 clk = ~clk;

  typedef struct {
    string tag;
    logic [7:0] rd;
    logic ir, sv, wk;
    logic [15:0] va;
    logic [3:0] id;
    logic [1:0] gl, cl;
  } item_t;

  item_t q[$];
  event sample_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [1:0] sh_lvl [12];
  int sh_stk[$];

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic expect_now(string tag);
    item_t it;
    int best, bid, top;
    bit f;
    f = 0; best = 0; bid = 0;
    for (int i = 0; i < 12; i++)
      if (irq_req[i] && irq_en[i] && (!f || sh_lvl[i] > best)) begin
        f = 1; best = sh_lvl[i]; bid = i;
      end
    top = (sh_stk.size() == 0) ? 0 : sh_stk[$];
    it.tag = tag;
    it.ir = f && (sh_stk.size() == 0 || best > top);
    it.wk = |(irq_req & irq_en);
    it.sv = sh_stk.size() != 0;
    it.cl = 2'(top);
    it.id = it.ir ? 4'(bid) : 4'd0;
    it.gl = it.ir ? 2'(best) : 2'd0;
    it.va = it.ir ? 16'(16'hFFFA - 2*bid) : 16'h0;
    it.rd = '0;
    if (reg_addr != 2'd3)
      for (int k = 0; k < 4; k++) it.rd[2*k +: 2] = sh_lvl[reg_addr*4 + k];
    q.push_back(it);
    -> sample_ev;
    #1;
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(sample_ev);
      e = q.pop_front();
      n_chk++;
      if ({int_req, in_service, wake, vec_addr, grant_id, grant_lvl, cur_lvl, reg_rdata} !==
          {e.ir, e.sv, e.wk, e.va, e.id, e.gl, e.cl, e.rd}) begin
        n_fail++;
        $display("FAIL %s: got req=%b sv=%b wk=%b vec=%h id=%0d gl=%0d cl=%0d rd=%h exp req=%b sv=%b wk=%b vec=%h id=%0d gl=%0d cl=%0d rd=%h",
          e.tag, int_req, in_service, wake, vec_addr, grant_id, grant_lvl, cur_lvl, reg_rdata,
          e.ir, e.sv, e.wk, e.va, e.id, e.gl, e.cl, e.rd);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0;
    if (a != 2'd3) for (int k = 0; k < 4; k++) sh_lvl[a*4 + k] = d[2*k +: 2];
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
    if (int_req_model()) sh_stk.push_back(model_best());
  endtask

  function automatic int model_best();
    int b; bit f; f = 0; b = 0;
    for (int i = 0; i < 12; i++)
      if (irq_req[i] && irq_en[i] && (!f || sh_lvl[i] > b)) begin f = 1; b = sh_lvl[i]; end
    return b;
  endfunction

  function automatic bit int_req_model();
    bit f = |(irq_req & irq_en);
    return f && (sh_stk.size() == 0 || model_best() > sh_stk[$]);
  endfunction

  task automatic do_reti(input bit with_ack);
    reti = 1; ack = with_ack; tick(); reti = 0; ack = 0;
    if (sh_stk.size() != 0) void'(sh_stk.pop_back());
  endtask

  task automatic set_in(input logic [11:0] r, input logic [11:0] e);
    irq_req = r; irq_en = e; #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 12; i++) sh_lvl[i] = 0;
    #1; expect_now("R1 reset asserted");
    repeat (2) tick();
    rst_n = 1; tick();
    for (int a = 0; a < 3; a++) begin reg_addr = 2'(a); #1; expect_now("R1 reset fields"); end
    // R2 map: sources 0 lvl1, 3 lvl2, 7 lvl3, 5 lvl0
    wr(2'd0, 8'h81); reg_addr = 2'd0; #1; expect_now("R2 readback addr0");
    wr(2'd1, 8'hC0); expect_now("R2 readback addr1");
    wr(2'd2, 8'h00); expect_now("R2 readback addr2");
    wr(2'd3, 8'hFF); expect_now("R3 addr3 reads zero");
    reg_addr = 2'd0; #1; expect_now("R3 addr0 untouched");
    reg_addr = 2'd1; #1; expect_now("R3 addr1 untouched");
    set_in(12'h0A9, 12'h000); expect_now("R4 pending but disabled");
    set_in(12'h000, 12'hFFF); expect_now("R4 enabled not pending");
    set_in(12'h020, 12'h020); expect_now("R4 R7 single source 5 level0");
    set_in(12'h0A9, 12'hFFF); expect_now("R5 level3 source 7 wins");
    set_in(12'h0A9, 12'h07F); expect_now("R5 level2 source 3 wins");
    wr(2'd1, 8'h04); // source 5 -> level1, source 7 -> 0
    set_in(12'h021, 12'hFFF); expect_now("R6 tie level1 source0 beats 5");
    set_in(12'h800, 12'h800); expect_now("R7 source 11 vector FFE4");
    set_in(12'h001, 12'h001); expect_now("R7 source 0 vector FFFA");
    do_reti(0); expect_now("R9 reti on empty ignored");
    // nesting: source 0 lvl1 acknowledged
    do_ack(); expect_now("R8 push level1");
    set_in(12'h021, 12'hFFF); expect_now("R8 equal level not offered");
    wr(2'd1, 8'hC4); // source7 lvl3 back
    set_in(12'h009, 12'hFFF); expect_now("R8 level2 beats service level1");
    do_ack(); expect_now("R8 push level2");
    set_in(12'h088, 12'hFFF); expect_now("R8 level3 offered over 2");
    do_ack(); expect_now("R8 push level3");
    set_in(12'hFFF, 12'hFFF); expect_now("R8 nothing beats level3 wake stays");
    do_ack(); expect_now("R10 ack without offer no push");
    do_reti(1); expect_now("R9 ack with reti pops only");
    do_reti(0); expect_now("R9 pop restores level1");
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    set_in(12'h010, 12'h010); reg_addr = 2'd0; #1; expect_now("R8 level0 blocked while serving");
    do_ack(); expect_now("R8 ack blocked no push");
    do_reti(0); expect_now("R9 pop to empty offers level0");
    // fill all four levels: sources 0..3 at levels 0..3
    wr(2'd0, 8'hE4);
    set_in(12'h001, 12'h00F); do_ack(); expect_now("R10 depth1");
    set_in(12'h002, 12'h00F); do_ack(); expect_now("R10 depth2");
    set_in(12'h004, 12'h00F); do_ack(); expect_now("R10 depth3");
    set_in(12'h008, 12'h00F); do_ack(); expect_now("R10 depth4 level3");
    set_in(12'h00F, 12'h00F); do_ack(); expect_now("R10 full no further push");
    for (int k = 0; k < 4; k++) begin do_reti(0); expect_now("R9 unwind"); end
    tick();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule